// File: doc/BRIEF.md
# Process-Tagged Fully Associative Translation Buffer

This block caches recent virtual-to-physical page translations so that a memory pipeline does not have to walk the page tables on every access. Each entry holds a virtual page number, the process identifier that owns it, a physical page number and two access-right bits. A lookup compares the requested page and the current process against every entry at once. The registered response arrives on the next cycle and reports a hit, a miss, or a protection fault.

Entries are loaded through a fill port that a page-table walker drives. Two maintenance commands are provided. A global flush clears every entry. A targeted invalidate removes the single mapping that belongs to one page of one process. Because every entry carries its owner's identifier, a context switch only needs a change of the current process input and no flush. When a fill finds no free slot, a victim is chosen. A parameter selects the victim policy: least recently used, or a pseudo-random pick from a shift-register sequence.

Each cycle, a combinational operation selector picks one of four operations: OP_IDLE, OP_FLUSH, OP_INVAL or OP_FILL. OP_FLUSH is taken whenever the flush input is high. Otherwise OP_INVAL is taken when the invalidate input is high. Otherwise OP_FILL is taken when the fill input is high. If none of these inputs is high, the selector falls back to OP_IDLE. Each operation updates the table at the clock edge that closes the cycle, and the selector then makes a fresh choice. The block holds no other control state.

Top module: `tlb_xlate`

## Requirements
- R1: A lookup (lk_valid=1) produces rsp_valid=1 exactly one cycle later. A hit requires an entry that is valid, whose page number equals lk_vpn and whose process identifier equals lk_pid. With no lookup in the previous cycle, rsp_valid, rsp_hit and rsp_fault are 0.
- R2: On a hit, rsp_ppn and rsp_rights return the stored physical page and rights. Rights bit 0 means readable and bit 1 means writable.
- R3: An entry whose page number matches but whose process identifier differs does not hit. Two processes can hold the same virtual page with different translations at the same time.
- R4: A lookup with lk_write=1 that matches an entry whose rights bit 1 is 0 gives rsp_fault=1 and rsp_hit=0. A read of the same entry hits. rsp_fault is only ever raised for write lookups.
- R5: flush_all invalidates every entry, so every lookup issued from the next cycle onward misses until a new fill is made.
- R6: An invalidate given a page number and a process identifier clears only the entry matching both. All other entries keep hitting.
- R7: A fill whose page number and process identifier match an existing entry overwrites that entry. The table never holds two entries that match the same lookup.
- R8: A fill with no matching entry uses the lowest-numbered free entry. If no entry is free, the victim chosen by the policy is replaced. The default policy is least recently used, where both a fill and a lookup match count as a use.
- R9: A lookup made in the same cycle as a fill sees the table as it was before that fill.
- R10: Only one command acts per cycle. Flush takes priority over invalidate, and invalidate takes priority over fill. A lower-priority command issued in the same cycle is dropped.
- R11: After reset, every entry is invalid and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_pid | input | 6 | Current process identifier |
| lk_write | input | 1 | Lookup is a write access |
| fill_en | input | 1 | Fill command from the walker |
| fill_vpn | input | 20 | Fill virtual page number |
| fill_pid | input | 6 | Fill process identifier |
| fill_ppn | input | 20 | Fill physical page number |
| fill_rights | input | 2 | Fill rights (bit 0 read, bit 1 write) |
| inv_en | input | 1 | Single-entry invalidate command |
| inv_vpn | input | 20 | Invalidate virtual page number |
| inv_pid | input | 6 | Invalidate process identifier |
| flush_all | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Translation found and allowed |
| rsp_fault | output | 1 | Write to an entry without write permission |
| rsp_ppn | output | 20 | Physical page number on a match, else 0 |
| rsp_rights | output | 2 | Rights of the matched entry, else 0 |

## Verification
A lookup response is registered, so it is due on the first clock edge after the request. The bench drives a request at a falling edge and reads the response at the next falling edge. A fill, invalidate or flush changes the table at the edge that ends its cycle. Its effect is therefore first visible to a lookup issued in the following cycle, and it shows up in that lookup's response one edge later. The bench always issues the command, then the lookup, then reads the response. The same-cycle case for R9 is driven on purpose with both inputs in one cycle, and the bench expects the pre-fill answer.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    // Index of each permission inside the rights field
    localparam int RIGHT_RD = 0;
    localparam int RIGHT_WR = 1;
    localparam int RIGHTS_W = 2;

    // Operation applied to the table in the current cycle
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_FLUSH = 2'd1,
        OP_INVAL = 2'd2,
        OP_FILL  = 2'd3
    } tbl_op_e;
endpackage

// File: rtl/tlb_match.sv
// Parallel tag compare: one comparator per entry
module tlb_match #(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int PID_W = 6
) (
    input  logic [N-1:0]     ent_valid,
    input  logic [VPN_W-1:0] ent_vpn [N],
    input  logic [PID_W-1:0] ent_pid [N],
    input  logic [VPN_W-1:0] q_vpn,
    input  logic [PID_W-1:0] q_pid,
    output logic [N-1:0]     match
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = ent_valid[g] && (ent_vpn[g] == q_vpn) && (ent_pid[g] == q_pid);
    end
endmodule

// File: rtl/tlb_pick.sv
// Lowest-set-bit encoder
module tlb_pick #(
    parameter int N  = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
// Replacement choice: age ranking or shift-register sequence
module tlb_victim #(
    parameter int N       = 16,
    parameter bit USE_LRU = 1'b1,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] victim_idx
);
    if (USE_LRU) begin : g_lru
        // ages form a permutation of 0..N-1; 0 = most recent
        logic [IW-1:0] age [N];
        logic [IW-1:0] touched_age;

        assign touched_age = age[touch_idx];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < N; i++) age[i] <= IW'(i);
            end else if (touch_en) begin
                for (int i = 0; i < N; i++) begin
                    if (IW'(i) == touch_idx) age[i] <= '0;
                    else if (age[i] < touched_age) age[i] <= age[i] + 1'b1;
                end
            end
        end

        always_comb begin
            victim_idx = '0;
            for (int i = 0; i < N; i++) begin
                if (age[i] == IW'(N - 1)) victim_idx = IW'(i);
            end
        end
    end else begin : g_rand
        localparam logic [15:0] SEED = 16'hACE1;
        logic [15:0] lfsr;
        logic [15:0] lfsr_step;
        logic [15:0] lfsr_mix;

        assign lfsr_step = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
        assign lfsr_mix  = lfsr_step ^ 16'(touch_idx);

        always_ff @(posedge clk) begin
            if (!rst_n) lfsr <= SEED;
            else if (touch_en) lfsr <= (lfsr_mix == 16'h0000) ? SEED : lfsr_mix;
            else lfsr <= lfsr_step;
        end

        assign victim_idx = lfsr[IW-1:0];
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int N       = 16,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int PID_W   = 6,
    parameter bit USE_LRU = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_valid,
    input  logic [VPN_W-1:0]    lk_vpn,
    input  logic [PID_W-1:0]    lk_pid,
    input  logic                lk_write,
    input  logic                fill_en,
    input  logic [VPN_W-1:0]    fill_vpn,
    input  logic [PID_W-1:0]    fill_pid,
    input  logic [PPN_W-1:0]    fill_ppn,
    input  logic [RIGHTS_W-1:0] fill_rights,
    input  logic                inv_en,
    input  logic [VPN_W-1:0]    inv_vpn,
    input  logic [PID_W-1:0]    inv_pid,
    input  logic                flush_all,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic                rsp_fault,
    output logic [PPN_W-1:0]    rsp_ppn,
    output logic [RIGHTS_W-1:0] rsp_rights
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    // Table storage
    logic [N-1:0]          ent_valid;
    logic [VPN_W-1:0]      ent_vpn    [N];
    logic [PID_W-1:0]      ent_pid    [N];
    logic [PPN_W-1:0]      ent_ppn    [N];
    logic [RIGHTS_W-1:0]   ent_rights [N];

    // Operation selector
    tbl_op_e               op;
    logic [VPN_W-1:0]      cm_vpn;
    logic [PID_W-1:0]      cm_pid;

    always_comb begin
        if (flush_all)    op = OP_FLUSH;
        else if (inv_en)  op = OP_INVAL;
        else if (fill_en) op = OP_FILL;
        else              op = OP_IDLE;
    end

    assign cm_vpn = (op == OP_INVAL) ? inv_vpn : fill_vpn;
    assign cm_pid = (op == OP_INVAL) ? inv_pid : fill_pid;

    // Lookup side
    logic [N-1:0]  lk_match;
    logic          lk_any;
    logic [IW-1:0] lk_idx;

    tlb_match #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_lk_match (
        .ent_valid (ent_valid),
        .ent_vpn   (ent_vpn),
        .ent_pid   (ent_pid),
        .q_vpn     (lk_vpn),
        .q_pid     (lk_pid),
        .match     (lk_match)
    );

    tlb_pick #(.N(N)) u_lk_pick (
        .vec (lk_match),
        .any (lk_any),
        .idx (lk_idx)
    );

    // Command side
    logic [N-1:0]  cm_match;
    logic          cm_any;
    logic [IW-1:0] cm_idx;

    tlb_match #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_cm_match (
        .ent_valid (ent_valid),
        .ent_vpn   (ent_vpn),
        .ent_pid   (ent_pid),
        .q_vpn     (cm_vpn),
        .q_pid     (cm_pid),
        .match     (cm_match)
    );

    tlb_pick #(.N(N)) u_cm_pick (
        .vec (cm_match),
        .any (cm_any),
        .idx (cm_idx)
    );

    // Free-slot search
    logic          free_any;
    logic [IW-1:0] free_idx;

    tlb_pick #(.N(N)) u_free_pick (
        .vec (~ent_valid),
        .any (free_any),
        .idx (free_idx)
    );

    // Replacement
    logic          touch_en;
    logic [IW-1:0] touch_idx;
    logic [IW-1:0] victim_idx;
    logic [IW-1:0] fill_idx;

    assign fill_idx = cm_any   ? cm_idx   :
                      free_any ? free_idx : victim_idx;

    // a fill's use takes precedence over a lookup's use in the same cycle
    assign touch_en  = (op == OP_FILL) || (lk_valid && lk_any);
    assign touch_idx = (op == OP_FILL) ? fill_idx : lk_idx;

    tlb_victim #(.N(N), .USE_LRU(USE_LRU)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .victim_idx (victim_idx)
    );

    // Table state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
            for (int i = 0; i < N; i++) begin
                ent_vpn[i]    <= '0;
                ent_pid[i]    <= '0;
                ent_ppn[i]    <= '0;
                ent_rights[i] <= '0;
            end
        end else begin
            unique case (op)
                OP_FLUSH: ent_valid <= '0;
                OP_INVAL: ent_valid <= ent_valid & ~cm_match;
                OP_FILL: begin
                    ent_valid[fill_idx]  <= 1'b1;
                    ent_vpn[fill_idx]    <= fill_vpn;
                    ent_pid[fill_idx]    <= fill_pid;
                    ent_ppn[fill_idx]    <= fill_ppn;
                    ent_rights[fill_idx] <= fill_rights;
                end
                OP_IDLE: ;
                default: ;
            endcase
        end
    end

    // Response outputs
    logic wr_denied;
    assign wr_denied = lk_write && !ent_rights[lk_idx][RIGHT_WR];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_ppn    <= '0;
            rsp_rights <= '0;
        end else begin
            rsp_valid  <= lk_valid;
            rsp_hit    <= lk_valid && lk_any && !wr_denied;
            rsp_fault  <= lk_valid && lk_any && wr_denied;
            rsp_ppn    <= (lk_valid && lk_any) ? ent_ppn[lk_idx]    : '0;
            rsp_rights <= (lk_valid && lk_any) ? ent_rights[lk_idx] : '0;
        end
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int N     = 16,
    parameter int VPN_W = 20,
    parameter int PID_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic [VPN_W-1:0] lk_vpn,
    input logic [PID_W-1:0] lk_pid,
    input logic             lk_write,
    input logic             inv_en,
    input logic [VPN_W-1:0] inv_vpn,
    input logic [PID_W-1:0] inv_pid,
    input logic             flush_all,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_fault,
    input logic [N-1:0]     lk_match
);
    // R1
    rsp_follows_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R1
    rsp_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault));

    // R4
    hit_fault_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_fault));

    // R4
    fault_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_write) |=> !rsp_fault);

    // R5
    flush_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (lk_valid |=> (!rsp_hit && !rsp_fault)));

    // R6
    inval_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !flush_all) |=>
            ((lk_valid && lk_vpn == $past(inv_vpn) && lk_pid == $past(inv_pid))
                |=> (!rsp_hit && !rsp_fault)));

    // R7
    no_duplicate_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
endmodule

bind tlb_xlate tlb_xlate_chk #(.N(N), .VPN_W(VPN_W), .PID_W(PID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_vpn    (lk_vpn),
    .lk_pid    (lk_pid),
    .lk_write  (lk_write),
    .inv_en    (inv_en),
    .inv_vpn   (inv_vpn),
    .inv_pid   (inv_pid),
    .flush_all (flush_all),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_fault (rsp_fault),
    .lk_match  (lk_match)
);

// File: tb/test_tlb_xlate.sv
module test_tlb_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid, lk_write, fill_en, inv_en, flush_all;
    logic [19:0] lk_vpn, fill_vpn, inv_vpn, fill_ppn;
    logic [5:0]  lk_pid, fill_pid, inv_pid;
    logic [1:0]  fill_rights;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [19:0] rsp_ppn;
    logic [1:0]  rsp_rights;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_xlate i_tlb_xlate (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_pid(lk_pid), .lk_write(lk_write),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
        .fill_ppn(fill_ppn), .fill_rights(fill_rights),
        .inv_en(inv_en), .inv_vpn(inv_vpn), .inv_pid(inv_pid),
        .flush_all(flush_all),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_ppn(rsp_ppn), .rsp_rights(rsp_rights)
    );

    // op: 0 = fill, 1 = lookup. For lookups ppn holds the expected page.
    typedef struct packed {
        logic        op;
        logic [19:0] vpn;
        logic [5:0]  pid;
        logic [19:0] ppn;
        logic [1:0]  rights;
        logic        wr;
        logic        ehit;
        logic        efault;
        logic [15:0] tag;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 20'h12345, 6'd3, 20'hAAAAA, 2'b11, 1'b0, 1'b0, 1'b0, "R2"},
        '{1'b0, 20'h00100, 6'd3, 20'h00042, 2'b01, 1'b0, 1'b0, 1'b0, "R4"},
        '{1'b1, 20'h12345, 6'd3, 20'hAAAAA, 2'b00, 1'b0, 1'b1, 1'b0, "R2"},
        '{1'b1, 20'h12345, 6'd4, 20'h00000, 2'b00, 1'b0, 1'b0, 1'b0, "R3"},
        '{1'b0, 20'h12345, 6'd4, 20'h0BEEF, 2'b11, 1'b0, 1'b0, 1'b0, "R3"},
        '{1'b1, 20'h12345, 6'd4, 20'h0BEEF, 2'b00, 1'b0, 1'b1, 1'b0, "R3"},
        '{1'b1, 20'h12345, 6'd3, 20'hAAAAA, 2'b00, 1'b0, 1'b1, 1'b0, "R3"},
        '{1'b1, 20'h00100, 6'd3, 20'h00000, 2'b00, 1'b1, 1'b0, 1'b1, "R4"},
        '{1'b1, 20'h00100, 6'd3, 20'h00042, 2'b00, 1'b0, 1'b1, 1'b0, "R4"},
        '{1'b1, 20'h00200, 6'd3, 20'h00000, 2'b00, 1'b0, 1'b0, 1'b0, "R1"},
        '{1'b0, 20'h12345, 6'd3, 20'h11111, 2'b11, 1'b0, 1'b0, 1'b0, "R7"},
        '{1'b1, 20'h12345, 6'd3, 20'h11111, 2'b00, 1'b1, 1'b1, 1'b0, "R7"}
    };

    task automatic idle_inputs();
        lk_valid = 1'b0; lk_write = 1'b0; lk_vpn = '0; lk_pid = '0;
        fill_en = 1'b0; fill_vpn = '0; fill_pid = '0; fill_ppn = '0; fill_rights = '0;
        inv_en = 1'b0; inv_vpn = '0; inv_pid = '0; flush_all = 1'b0;
    endtask

    // all tasks start and end at a falling edge
    task automatic do_fill(input logic [19:0] v, input logic [5:0] p,
                           input logic [19:0] pp, input logic [1:0] r);
        fill_en = 1'b1; fill_vpn = v; fill_pid = p; fill_ppn = pp; fill_rights = r;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic do_inval(input logic [19:0] v, input logic [5:0] p);
        inv_en = 1'b1; inv_vpn = v; inv_pid = p;
        @(negedge clk);
        inv_en = 1'b0;
    endtask

    task automatic expect_rsp(input logic eh, input logic ef, input logic [19:0] eppn,
                              input string tag);
        logic [19:0] want;
        want = eh ? eppn : rsp_ppn;
        checks++;
        if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_fault !== ef || rsp_ppn !== want) begin
            errors++;
            $display("FAIL %s: valid=%b hit=%b fault=%b ppn=%h expected valid=1 hit=%b fault=%b ppn=%h",
                     tag, rsp_valid, rsp_hit, rsp_fault, rsp_ppn, eh, ef, want);
        end
    endtask

    task automatic check_lookup(input logic [19:0] v, input logic [5:0] p, input logic wr,
                                input logic eh, input logic ef, input logic [19:0] eppn,
                                input string tag);
        lk_valid = 1'b1; lk_vpn = v; lk_pid = p; lk_write = wr;
        @(negedge clk);
        lk_valid = 1'b0; lk_write = 1'b0;
        expect_rsp(eh, ef, eppn, tag);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R11: outputs idle while in reset
        checks++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_fault !== 1'b0 || rsp_ppn !== 20'h0) begin
            errors++;
            $display("FAIL R11: valid=%b hit=%b fault=%b ppn=%h expected all 0",
                     rsp_valid, rsp_hit, rsp_fault, rsp_ppn);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R11: nothing stored after reset
        check_lookup(20'h00000, 6'd0, 1'b0, 1'b0, 1'b0, 20'h0, "R11");

        // vector table
        for (int k = 0; k < NV; k++) begin
            if (VEC[k].op == 1'b0)
                do_fill(VEC[k].vpn, VEC[k].pid, VEC[k].ppn, VEC[k].rights);
            else
                check_lookup(VEC[k].vpn, VEC[k].pid, VEC[k].wr, VEC[k].ehit,
                             VEC[k].efault, VEC[k].ppn, $sformatf("%s", VEC[k].tag));
        end

        // R5: flush clears everything
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        check_lookup(20'h12345, 6'd3, 1'b0, 1'b0, 1'b0, 20'h0, "R5");
        check_lookup(20'h12345, 6'd4, 1'b0, 1'b0, 1'b0, 20'h0, "R5");

        // fill the whole table, then rewrite one page: R7 no extra slot used
        for (int i = 0; i < 16; i++) do_fill(20'(i), 6'd1, 20'(32'h100 + i), 2'b11);
        do_fill(20'd7, 6'd1, 20'h00777, 2'b11);
        check_lookup(20'd0, 6'd1, 1'b0, 1'b1, 1'b0, 20'h00100, "R7");
        // R8: least recently used entry (page 1) is the victim
        do_fill(20'd100, 6'd1, 20'h0ABCD, 2'b11);
        check_lookup(20'd1, 6'd1, 1'b0, 1'b0, 1'b0, 20'h0, "R8");
        check_lookup(20'd2, 6'd1, 1'b0, 1'b1, 1'b0, 20'h00102, "R8");
        check_lookup(20'd100, 6'd1, 1'b0, 1'b1, 1'b0, 20'h0ABCD, "R8");
        check_lookup(20'd7, 6'd1, 1'b0, 1'b1, 1'b0, 20'h00777, "R7");

        // R6: only the named entry goes away
        do_inval(20'd9, 6'd1);
        check_lookup(20'd9, 6'd1, 1'b0, 1'b0, 1'b0, 20'h0, "R6");
        check_lookup(20'd10, 6'd1, 1'b0, 1'b1, 1'b0, 20'h0010A, "R6");
        // R8: freed slot used first, so the oldest page (3) survives
        do_fill(20'd200, 6'd1, 20'h00200, 2'b11);
        check_lookup(20'd3, 6'd1, 1'b0, 1'b1, 1'b0, 20'h00103, "R8");
        check_lookup(20'd200, 6'd1, 1'b0, 1'b1, 1'b0, 20'h00200, "R8");

        // R9: lookup alongside a fill of the same page sees the old table
        lk_valid = 1'b1; lk_vpn = 20'd300; lk_pid = 6'd1; lk_write = 1'b0;
        fill_en = 1'b1; fill_vpn = 20'd300; fill_pid = 6'd1; fill_ppn = 20'h00300; fill_rights = 2'b11;
        @(negedge clk);
        lk_valid = 1'b0; fill_en = 1'b0;
        expect_rsp(1'b0, 1'b0, 20'h0, "R9");
        check_lookup(20'd300, 6'd1, 1'b0, 1'b1, 1'b0, 20'h00300, "R9");

        // R10: flush wins over a fill in the same cycle
        flush_all = 1'b1;
        fill_en = 1'b1; fill_vpn = 20'd400; fill_pid = 6'd1; fill_ppn = 20'h00400; fill_rights = 2'b11;
        @(negedge clk);
        flush_all = 1'b0; fill_en = 1'b0;
        check_lookup(20'd400, 6'd1, 1'b0, 1'b0, 1'b0, 20'h0, "R10");
        check_lookup(20'd300, 6'd1, 1'b0, 1'b0, 1'b0, 20'h0, "R5");

        // R10: invalidate wins over a fill in the same cycle
        do_fill(20'd500, 6'd2, 20'h00500, 2'b11);
        inv_en = 1'b1; inv_vpn = 20'd500; inv_pid = 6'd2;
        fill_en = 1'b1; fill_vpn = 20'd501; fill_pid = 6'd2; fill_ppn = 20'h00501; fill_rights = 2'b11;
        @(negedge clk);
        inv_en = 1'b0; fill_en = 1'b0;
        check_lookup(20'd500, 6'd2, 1'b0, 1'b0, 1'b0, 20'h0, "R10");
        check_lookup(20'd501, 6'd2, 1'b0, 1'b0, 1'b0, 20'h0, "R10");

        // R1: idle cycle gives no response
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
            errors++;
            $display("FAIL R1: valid=%b hit=%b expected valid=0 hit=0", rsp_valid, rsp_hit);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule